// File: doc/BRIEF.md
# Robbed-Bit Signaling Capture Bank

This block pulls the robbed-bit signaling out of a received 24-channel T1 stream. An external framer delivers the stream one bit per strobe. With each bit it gives the frame number within the multiframe, the channel number and the bit position within the 8-bit timeslot. The framer also supplies a one-cycle multiframe boundary pulse, a framing-mode select and a loss-of-sync flag. During each multiframe the robbed bits are collected into a shadow buffer. At the boundary the whole buffer moves in one cycle into twelve byte-wide readable registers, so software never sees a mix of two multiframes.

Four bits per channel (A, B, C, D) are captured in the four-bit mode. In the two-bit mode only A and B arrive, and the C and D positions are refilled with the A and B values of the previous multiframe. Software can therefore poll at the same rate in both modes. A change in signaling from one multiframe to the next sets a sticky status bit. That bit drives a maskable active-low interrupt and is cleared by a status read.

Top module: `robsig_capture`

## Requirements
- R1: `reg_sel` values 0, 1 and 2 return bit A of channels 0–7, 8–15 and 16–23. Values 3–5 return bit B, 6–8 return C and 9–11 return D. Bit 0 of each byte is the lowest channel of its group. Values 12–15 read as zero.
- R2: A robbed bit is taken only on a strobe with `bit_idx` = 7 (the last bit of the timeslot) and `chan_idx` below 24. Bit A is taken in frame 6, B in frame 12, C in frame 18 and D in frame 24. All other bits and frames leave the captured values unchanged.
- R3: With `esf_mode` = 1, a boundary loads A, B, C and D from the multiframe just received.
- R4: With `esf_mode` = 0, a boundary loads A and B from the multiframe just received. C is loaded with the A value held before the boundary, and D with the B value held before the boundary.
- R5: The readable registers change only on the clock edge at which `mf_bnd` is high. In the middle of a multiframe they still show the previous multiframe.
- R6: If `sync_lost` is high during a boundary, the registers keep their values and no change is flagged.
- R7: At a boundary not under loss of sync, `chg_status` is set if any new A or B bit differs from its held value. In four-bit mode, a differing C or D bit also sets it. Identical signaling does not set it.
- R8: A one-cycle `stat_rd` clears `chg_status` on the next edge. If a change is detected in that same cycle, the bit stays set.
- R9: `irq_n` is low exactly when `chg_status` is 1 and `irq_en` is 1.

Ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One strobe per received line bit |
| bit_data | input | 1 | Received line bit |
| frame_num | input | 5 | Frame number within the multiframe, 1-based |
| chan_idx | input | 5 | Channel number, 0–23 |
| bit_idx | input | 3 | Bit position within the timeslot, 0 first, 7 last |
| mf_bnd | input | 1 | Single-cycle multiframe boundary pulse |
| esf_mode | input | 1 | 1 = four signaling bits, 0 = two bits |
| sync_lost | input | 1 | Loss-of-sync flag |
| stat_rd | input | 1 | Status read strobe; clears the change bit |
| irq_en | input | 1 | Interrupt enable mask |
| reg_sel | input | 4 | Register select for the read port |
| reg_rdata | output | 8 | Selected register contents |
| chg_status | output | 1 | Sticky signaling-change bit |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Every non-robbed bit and every non-signaling frame carries the inverse of the nearby signaling value. A capture from the wrong bit position or the wrong frame therefore shows up as an inverted register. Four-bit multiframes are run three ways: with all-new values, with repeated values, and with only the D bits altered. Together these separate detection on A/B from detection on C/D and from no detection at all. Two-bit multiframes show the C/D hand-down from the previous A/B. Repeating the same A/B in two-bit mode proves that the shifting C/D alone does not raise the flag. Separate directed multiframes cover a boundary under loss of sync, a masked interrupt, and a status read that coincides with a change.

// File: rtl/robsig_pkg.sv
package robsig_pkg;
    // Signaling letter order; also the bank order seen at the read port.
    typedef enum logic [1:0] {
        SIG_A = 2'd0,
        SIG_B = 2'd1,
        SIG_C = 2'd2,
        SIG_D = 2'd3
    } sig_e;

    localparam int NUM_SIG = 4;
endpackage

// File: rtl/robsig_shadow.sv
module robsig_shadow
    import robsig_pkg::*;
#(
    parameter int NUM_CH  = 24,
    parameter int FRAME_W = 5,
    parameter int CH_W    = 5,
    parameter int BIT_W   = 3,
    parameter int ROB_BIT = 7,
    parameter int FR_A    = 6,
    parameter int FR_B    = 12,
    parameter int FR_C    = 18,
    parameter int FR_D    = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bit_en,
    input  logic                             bit_data,
    input  logic [FRAME_W-1:0]               frame_num,
    input  logic [CH_W-1:0]                  chan_idx,
    input  logic [BIT_W-1:0]                 bit_idx,
    output logic [NUM_SIG-1:0][NUM_CH-1:0]   shadow
);
    localparam logic [NUM_SIG-1:0][FRAME_W-1:0] FR_POS =
        {FRAME_W'(FR_D), FRAME_W'(FR_C), FRAME_W'(FR_B), FRAME_W'(FR_A)};

    typedef struct packed {
        logic [NUM_SIG-1:0][NUM_CH-1:0] sh;
    } shd_t;

    shd_t s_d, s_q;
    logic rob_hit;

    always_comb begin
        s_d     = s_q;
        rob_hit = bit_en && (bit_idx == BIT_W'(ROB_BIT)) && (chan_idx < CH_W'(NUM_CH));
        if (rob_hit) begin
            for (int l = 0; l < NUM_SIG; l++) begin
                if (frame_num == FR_POS[l]) begin
                    s_d.sh[l][chan_idx] = bit_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shadow = s_q.sh;

    // R2: nothing is captured without a bit strobe
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(s_q.sh));

    // R2: a strobe on a non-robbed bit position captures nothing
    assert_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx != BIT_W'(ROB_BIT)) |=> $stable(s_q.sh));
endmodule

// File: rtl/robsig_bank.sv
module robsig_bank
    import robsig_pkg::*;
#(
    parameter int NUM_CH = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             mf_bnd,
    input  logic                             esf_mode,
    input  logic                             sync_lost,
    input  logic                             stat_rd,
    input  logic [NUM_SIG-1:0][NUM_CH-1:0]   shadow,
    output logic [NUM_SIG-1:0][NUM_CH-1:0]   regs,
    output logic                             chg_status
);
    typedef struct packed {
        logic [NUM_SIG-1:0][NUM_CH-1:0] r;
        logic                           chg;
    } bank_t;

    bank_t s_d, s_q;
    logic  upd;
    logic  diff_ab;
    logic  diff_cd;

    always_comb begin
        s_d     = s_q;
        upd     = mf_bnd && !sync_lost;
        diff_ab = (shadow[SIG_A] != s_q.r[SIG_A]) || (shadow[SIG_B] != s_q.r[SIG_B]);
        diff_cd = (shadow[SIG_C] != s_q.r[SIG_C]) || (shadow[SIG_D] != s_q.r[SIG_D]);
        if (upd) begin
            s_d.r[SIG_A] = shadow[SIG_A];
            s_d.r[SIG_B] = shadow[SIG_B];
            if (esf_mode) begin
                s_d.r[SIG_C] = shadow[SIG_C];
                s_d.r[SIG_D] = shadow[SIG_D];
            end else begin
                s_d.r[SIG_C] = s_q.r[SIG_A];
                s_d.r[SIG_D] = s_q.r[SIG_B];
            end
        end
        if (upd && (diff_ab || (esf_mode && diff_cd))) begin
            s_d.chg = 1'b1;
        end else if (stat_rd) begin
            s_d.chg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs       = s_q.r;
    assign chg_status = s_q.chg;

    // R5: readable registers move only at a boundary
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_bnd |=> $stable(s_q.r));

    // R6: a boundary under loss of sync changes nothing
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_bnd && sync_lost) |=> $stable(s_q.r));

    // R4: two-bit mode hands the old A down into C
    assert_handdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_bnd && !sync_lost && !esf_mode) |=> (s_q.r[SIG_C] == $past(s_q.r[SIG_A])));

    // R7: the change bit only rises from a live boundary
    assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.chg) |-> $past(mf_bnd && !sync_lost));

    // R8: a read with no boundary clears the change bit
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !mf_bnd) |=> !s_q.chg);
endmodule

// File: rtl/robsig_readmux.sv
module robsig_readmux
    import robsig_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int REG_W  = 8,
    parameter int SEL_W  = 4
) (
    input  logic [NUM_SIG-1:0][NUM_CH-1:0] regs,
    input  logic [SEL_W-1:0]               sel,
    output logic [REG_W-1:0]               rdata
);
    localparam int NUM_GRP  = NUM_CH / REG_W;
    localparam int NUM_REGS = NUM_SIG * NUM_GRP;

    logic [NUM_REGS-1:0][REG_W-1:0] bank_bytes;

    for (genvar l = 0; l < NUM_SIG; l++) begin : g_sig
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign bank_bytes[l*NUM_GRP + g] = regs[l][g*REG_W +: REG_W];
        end
    end

    always_comb begin
        if (int'(sel) < NUM_REGS) rdata = bank_bytes[sel];
        else                      rdata = '0;
    end
endmodule

// File: rtl/robsig_capture.sv
module robsig_capture
    import robsig_pkg::*;
#(
    parameter  int NUM_CH  = 24,
    parameter  int REG_W   = 8,
    parameter  int SLOT_W  = 8,
    parameter  int FRAME_W = 5,
    parameter  int CH_W    = 5,
    localparam int BIT_W   = $clog2(SLOT_W),
    localparam int SEL_W   = $clog2(NUM_SIG * NUM_CH / REG_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_data,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic [CH_W-1:0]    chan_idx,
    input  logic [BIT_W-1:0]   bit_idx,
    input  logic               mf_bnd,
    input  logic               esf_mode,
    input  logic               sync_lost,
    input  logic               stat_rd,
    input  logic               irq_en,
    input  logic [SEL_W-1:0]   reg_sel,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               chg_status,
    output logic               irq_n
);
    logic [NUM_SIG-1:0][NUM_CH-1:0] shadow_w;
    logic [NUM_SIG-1:0][NUM_CH-1:0] regs_w;

    robsig_shadow #(
        .NUM_CH (NUM_CH),
        .FRAME_W(FRAME_W),
        .CH_W   (CH_W),
        .BIT_W  (BIT_W),
        .ROB_BIT(SLOT_W - 1)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_data (bit_data),
        .frame_num(frame_num),
        .chan_idx (chan_idx),
        .bit_idx  (bit_idx),
        .shadow   (shadow_w)
    );

    robsig_bank #(
        .NUM_CH(NUM_CH)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mf_bnd    (mf_bnd),
        .esf_mode  (esf_mode),
        .sync_lost (sync_lost),
        .stat_rd   (stat_rd),
        .shadow    (shadow_w),
        .regs      (regs_w),
        .chg_status(chg_status)
    );

    robsig_readmux #(
        .NUM_CH(NUM_CH),
        .REG_W (REG_W),
        .SEL_W (SEL_W)
    ) u_rmux (
        .regs (regs_w),
        .sel  (reg_sel),
        .rdata(reg_rdata)
    );

    assign irq_n = ~(chg_status & irq_en);

    // R9: the interrupt is never low without a pending change
    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> chg_status);

    // R9: a cleared mask keeps the interrupt high
    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);
endmodule

// File: tb/test_robsig_capture.sv
`timescale 1ns/1ps
module test_robsig_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_data = 1'b0;
    logic [4:0] frame_num = 5'd1;
    logic [4:0] chan_idx = 5'd0;
    logic [2:0] bit_idx = 3'd0;
    logic       mf_bnd = 1'b0;
    logic       esf_mode = 1'b1;
    logic       sync_lost = 1'b0;
    logic       stat_rd = 1'b0;
    logic       irq_en = 1'b1;
    logic [3:0] reg_sel = 4'd0;
    logic [7:0] reg_rdata;
    logic       chg_status;
    logic       irq_n;

    robsig_capture i_robsig_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_data  (bit_data),
        .frame_num (frame_num),
        .chan_idx  (chan_idx),
        .bit_idx   (bit_idx),
        .mf_bnd    (mf_bnd),
        .esf_mode  (esf_mode),
        .sync_lost (sync_lost),
        .stat_rd   (stat_rd),
        .irq_en    (irq_en),
        .reg_sel   (reg_sel),
        .reg_rdata (reg_rdata),
        .chg_status(chg_status),
        .irq_n     (irq_n)
    );

    always #2 clk = ~clk;

    // scoreboard queues
    logic [95:0] q_img[$];
    logic        q_chg[$];
    logic        q_irq[$];
    string       q_tag[$];
    bit          mon_busy = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;

    // reference model
    logic [23:0] mA = '0, mB = '0, mC = '0, mD = '0;
    logic        mchg = 1'b0;

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input string tag);
        q_img.push_back({mD, mC, mB, mA});
        q_chg.push_back(mchg);
        q_irq.push_back(!(mchg && irq_en));
        q_tag.push_back(tag);
        @(negedge clk);
        while (q_img.size() != 0 || mon_busy) @(negedge clk);
    endtask

    // monitor: pops expected images and compares with the read port
    initial begin
        forever begin
            logic [95:0] e_img;
            logic        e_chg, e_irq;
            string       e_tag;
            while (q_img.size() == 0) @(negedge clk);
            mon_busy = 1'b1;
            e_img = q_img.pop_front();
            e_chg = q_chg.pop_front();
            e_irq = q_irq.pop_front();
            e_tag = q_tag.pop_front();
            for (int s = 0; s < 16; s++) begin
                reg_sel = 4'(s);
                #0.2;
                check(e_tag, $sformatf("R1 reg%0d", s), reg_rdata,
                      (s < 12) ? e_img[s*8 +: 8] : 8'h00);
            end
            check(e_tag, "chg_status", {7'b0, chg_status}, {7'b0, e_chg});
            check(e_tag, "irq_n (R9)", {7'b0, irq_n}, {7'b0, e_irq});
            mon_busy = 1'b0;
        end
    end

    function automatic logic nearest_val(input int f, input int ch,
                                         input logic [23:0] a, b, c, d);
        if (f <= 6)       return a[ch];
        else if (f <= 12) return b[ch];
        else if (f <= 18) return c[ch];
        else              return d[ch];
    endfunction

    // driver: one multiframe followed by a boundary pulse
    task automatic run_mf(input bit m_esf, input logic [23:0] a, b, c, d,
                          input bit lost, input bit rd_bnd, input bit mid,
                          input string tag);
        int   nfr;
        logic diff;
        logic [23:0] nC, nD;
        nfr       = m_esf ? 24 : 12;
        esf_mode  = m_esf;
        sync_lost = lost;
        for (int f = 1; f <= nfr; f++) begin
            if (mid && f == 13) begin
                @(negedge clk);
                bit_en = 1'b0;
                push_exp("R5 mid-multiframe");
            end
            for (int ch = 0; ch < 24; ch++) begin
                for (int bi = 0; bi < 8; bi++) begin
                    logic v;
                    logic sigf;
                    @(negedge clk);
                    v         = nearest_val(f, ch, a, b, c, d);
                    sigf      = (f == 6) || (f == 12) || (m_esf && (f == 18 || f == 24));
                    bit_en    = 1'b1;
                    frame_num = 5'(f);
                    chan_idx  = 5'(ch);
                    bit_idx   = 3'(bi);
                    // R2: decoy bits carry the inverse value
                    bit_data  = (bi == 7 && sigf) ? v : ~v;
                end
            end
        end
        @(negedge clk);
        bit_en  = 1'b0;
        mf_bnd  = 1'b1;
        stat_rd = rd_bnd;
        @(negedge clk);
        mf_bnd    = 1'b0;
        stat_rd   = 1'b0;
        sync_lost = 1'b0;
        if (!lost) begin
            diff = (a != mA) || (b != mB) || (m_esf && ((c != mC) || (d != mD)));
            nC   = m_esf ? c : mA;
            nD   = m_esf ? d : mB;
            mA = a; mB = b; mC = nC; mD = nD;
            mchg = diff ? 1'b1 : (rd_bnd ? 1'b0 : mchg);
        end else begin
            mchg = rd_bnd ? 1'b0 : mchg;
        end
        push_exp(tag);
    endtask

    task automatic do_rd();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        mchg = 1'b0;
        push_exp("R8 status read clears");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        push_exp("R1 reset state");
        // R3 R7: four-bit mode, all new; also the R5 mid check
        run_mf(1'b1, 24'hA5C3F0, 24'h0F1E2D, 24'h3C3C3C, 24'h96E187, 1'b0, 1'b0, 1'b1, "R3 R7 new four-bit");
        do_rd();
        // R7: identical signaling raises nothing
        run_mf(1'b1, 24'hA5C3F0, 24'h0F1E2D, 24'h3C3C3C, 24'h96E187, 1'b0, 1'b0, 1'b0, "R7 repeat no change");
        // R7: only D differs
        run_mf(1'b1, 24'hA5C3F0, 24'h0F1E2D, 24'h3C3C3C, 24'h96E186, 1'b0, 1'b0, 1'b0, "R7 D-only change");
        do_rd();
        // R4: two-bit mode hand-down
        run_mf(1'b0, 24'h123456, 24'hFEDCBA, 24'h0, 24'h0, 1'b0, 1'b0, 1'b0, "R4 two-bit first");
        do_rd();
        run_mf(1'b0, 24'h123456, 24'hFEDCBA, 24'h0, 24'h0, 1'b0, 1'b0, 1'b0, "R4 R7 two-bit repeat");
        // R6: loss of sync freezes
        run_mf(1'b0, 24'h0000FF, 24'hFF0000, 24'h0, 24'h0, 1'b1, 1'b0, 1'b0, "R6 sync lost");
        // R9: masked interrupt
        @(negedge clk);
        irq_en = 1'b0;
        run_mf(1'b1, 24'h5A5A5A, 24'h00FF00, 24'hC0FFEE, 24'h0BADF0, 1'b0, 1'b0, 1'b0, "R9 masked");
        @(negedge clk);
        irq_en = 1'b1;
        push_exp("R9 unmasked");
        do_rd();
        // R8: read coinciding with a change keeps the bit set
        run_mf(1'b1, 24'hFFFFFF, 24'h000001, 24'h800000, 24'h7FFFFE, 1'b0, 1'b1, 1'b0, "R8 change wins over read");
        // R8: read at a boundary without change clears
        run_mf(1'b1, 24'hFFFFFF, 24'h000001, 24'h800000, 24'h7FFFFE, 1'b0, 1'b1, 1'b0, "R8 read at quiet boundary");
        summary();
        $finish;
    end
endmodule